// File: doc/BRIEF.md
# Conditional Skip Evaluation Unit

This block settles, in a single clock, whether a 16-bit accumulator machine skips its next instruction. The instruction decoder presents a 5-bit skip code. The block tests that code against the accumulator, the one-bit link, six device ready flags and a flag that is high while the display processor runs. It raises a combinational skip request. On each clock edge where execution is enabled, it registers the updated program counter.

The program counter value that arrives here already points past the skip instruction. When the condition holds, the block adds one more, and the sum wraps within the 16-bit word. Device flags sit on a 6-bit bus with these indices: 0 keyboard, 1 teletype input, 2 teletype output, 3 paper-tape reader, 4 printer, 5 display 40 Hz sync.

Top module: `skip_unit`

## Requirements
- R1: While rstN is low, pcOut is 0, and pcOut stays 0 at the first edge after reset is released if execEn is low.
- R2: Code 1 requests a skip exactly when acc equals 0. Code 2 requests a skip exactly when acc is nonzero.
- R3: Code 3 requests a skip exactly when acc bit 15 is set.
- R4: Code 4 requests a skip exactly when link is 0. Code 5 requests a skip exactly when link is 1.
- R5: Code 8+2d requests a skip exactly when devReady[d] is 1, and code 9+2d exactly when devReady[d] is 0, for d in 0..5.
- R6: Code 6 requests a skip exactly when dispRunning is 0.
- R7: Codes 0, 7 and 20 through 31 never request a skip, whatever the other inputs are.
- R8: At an edge with execEn high, pcOut becomes (pcIn + skipReq) mod 65536, so 16'hFFFF plus a skip gives 0.
- R9: At an edge with execEn low, pcOut keeps its value. Each evaluation completes within one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| execEn | input | 1 | Register the program counter this edge |
| skipCode | input | 5 | Decoded skip code |
| acc | input | 16 | Accumulator |
| link | input | 1 | Link bit |
| devReady | input | 6 | Device ready flags, indexed as in the description |
| dispRunning | input | 1 | High while the display processor runs |
| pcIn | input | 16 | Program counter of the following instruction |
| skipReq | output | 1 | Skip condition met |
| pcOut | output | 16 | Registered updated program counter |

## Verification
On every cycle, the assertions check several things: the skip request for the accumulator, link and display codes; the silence of unknown codes; the hold of the counter while execution is disabled; and the step and wrap at enabled edges. The device pairs across all six flags, and the complete truth table of every code against every flag pattern, appear only in the bench's exhaustive sweep. The same holds for the reset value.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int CODE_W = 5;

  // Fixed code points; device pairs start at DEV_BASE, two codes per device
  localparam logic [CODE_W-1:0] CODE_NONE     = 5'd0;
  localparam logic [CODE_W-1:0] CODE_ACC_ZERO = 5'd1;
  localparam logic [CODE_W-1:0] CODE_ACC_NZ   = 5'd2;
  localparam logic [CODE_W-1:0] CODE_ACC_NEG  = 5'd3;
  localparam logic [CODE_W-1:0] CODE_LINK_0   = 5'd4;
  localparam logic [CODE_W-1:0] CODE_LINK_1   = 5'd5;
  localparam logic [CODE_W-1:0] CODE_DISP_OFF = 5'd6;
  localparam int DEV_BASE = 8;

  typedef struct packed {
    logic load;  // register the program counter this edge
    logic skip;  // add the extra step
  } pcStrobe_t;
endpackage

// File: rtl/skip_cond.sv
module skip_cond
  import skip_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int NUM_DEV = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execEn,
  input  logic [CODE_W-1:0] skipCode,
  input  logic [WORD_W-1:0] acc,
  input  logic              link,
  input  logic [NUM_DEV-1:0] devReady,
  input  logic              dispRunning,
  output pcStrobe_t         strobe
);
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int DEV_END   = DEV_BASE + 2 * NUM_DEV;

  logic [NUM_CODES-1:0] condVec;
  logic [NUM_DEV-1:0]   devTrue;
  logic [NUM_DEV-1:0]   devFalse;

  genvar g;
  generate
    for (g = 0; g < NUM_DEV; g++) begin : g_dev
      assign devTrue[g]  = devReady[g];
      assign devFalse[g] = ~devReady[g];
    end
  endgenerate

  always_comb begin
    condVec = '0;
    condVec[CODE_ACC_ZERO] = (acc == '0);
    condVec[CODE_ACC_NZ]   = (acc != '0);
    condVec[CODE_ACC_NEG]  = acc[WORD_W-1];
    condVec[CODE_LINK_0]   = ~link;
    condVec[CODE_LINK_1]   = link;
    condVec[CODE_DISP_OFF] = ~dispRunning;
    for (int d = 0; d < NUM_DEV; d++) begin
      condVec[DEV_BASE + 2*d]     = devTrue[d];
      condVec[DEV_BASE + 2*d + 1] = devFalse[d];
    end
  end

  assign strobe.skip = condVec[skipCode];
  assign strobe.load = execEn;

  // R2: accumulator zero pair
  a_r2_acc_zero: assert property (@(posedge clk) disable iff (!rstN)
    (skipCode == CODE_ACC_ZERO && acc == '0) |-> strobe.skip);
  a_r2_acc_nz: assert property (@(posedge clk) disable iff (!rstN)
    (skipCode == CODE_ACC_NZ && acc == '0) |-> !strobe.skip);
  // R3: sign test ignores the low bits
  a_r3_acc_pos: assert property (@(posedge clk) disable iff (!rstN)
    (skipCode == CODE_ACC_NEG && !acc[WORD_W-1]) |-> !strobe.skip);
  // R4: link pair
  a_r4_link: assert property (@(posedge clk) disable iff (!rstN)
    (skipCode == CODE_LINK_1 && link) |-> strobe.skip);
  // R6: running display suppresses the idle skip
  a_r6_disp: assert property (@(posedge clk) disable iff (!rstN)
    (skipCode == CODE_DISP_OFF && dispRunning) |-> !strobe.skip);
  // R7: unknown codes stay quiet
  a_r7_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (skipCode == CODE_NONE || skipCode == 5'd7 || int'(skipCode) >= DEV_END)
    |-> !strobe.skip);
endmodule

// File: rtl/pc_path.sv
module pc_path
  import skip_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobe_t         strobe,
  input  logic [WORD_W-1:0] pcIn,
  output logic [WORD_W-1:0] pcOut
);
  logic [WORD_W-1:0] pcNext;

  assign pcNext = pcIn + WORD_W'(strobe.skip);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pcOut <= '0;
    else if (strobe.load) pcOut <= pcNext;
  end

  // R9: disabled edge holds the counter
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(pcOut));
  // R8: no skip passes pcIn straight through
  a_r8_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.skip) |=> pcOut == $past(pcIn));
  // R8: skip from the top of the word wraps to zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.skip && pcIn == '1) |=> pcOut == '0);
endmodule

// File: rtl/skip_unit.sv
module skip_unit
  import skip_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int NUM_DEV = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               execEn,
  input  logic [CODE_W-1:0]  skipCode,
  input  logic [WORD_W-1:0]  acc,
  input  logic               link,
  input  logic [NUM_DEV-1:0] devReady,
  input  logic               dispRunning,
  input  logic [WORD_W-1:0]  pcIn,
  output logic               skipReq,
  output logic [WORD_W-1:0]  pcOut
);
  pcStrobe_t strobe;

  skip_cond #(.WORD_W(WORD_W), .NUM_DEV(NUM_DEV)) u_cond (
    .clk(clk), .rstN(rstN), .execEn(execEn), .skipCode(skipCode),
    .acc(acc), .link(link), .devReady(devReady),
    .dispRunning(dispRunning), .strobe(strobe)
  );

  pc_path #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pcIn(pcIn), .pcOut(pcOut)
  );

  assign skipReq = strobe.skip;
endmodule

// File: tb/skip_unit_tb.sv
`timescale 1ns/1ps
module skip_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execEn = 1'b0;
  logic [4:0]  skipCode = '0;
  logic [15:0] acc = '0;
  logic        link = 1'b0;
  logic [5:0]  devReady = '0;
  logic        dispRunning = 1'b0;
  logic [15:0] pcIn = '0;
  logic        skipReq;
  logic [15:0] pcOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  skip_unit u_dut (
    .clk(clk), .rstN(rstN), .execEn(execEn), .skipCode(skipCode),
    .acc(acc), .link(link), .devReady(devReady),
    .dispRunning(dispRunning), .pcIn(pcIn), .skipReq(skipReq), .pcOut(pcOut)
  );

  function automatic logic expSkip(input int code, input logic [15:0] a,
                                   input logic l, input logic [5:0] dr,
                                   input logic dsp);
    if (code == 1) return a == 16'd0;
    if (code == 2) return a != 16'd0;
    if (code == 3) return a[15];
    if (code == 4) return !l;
    if (code == 5) return l;
    if (code == 6) return !dsp;
    if (code >= 8 && code < 20) begin
      if (code % 2 == 0) return dr[(code - 8) / 2];
      return !dr[(code - 8) / 2];
    end
    return 1'b0;
  endfunction

  function automatic string reqOf(input int code);
    if (code == 1 || code == 2) return "R2";
    if (code == 3) return "R3";
    if (code == 4 || code == 5) return "R4";
    if (code == 6) return "R6";
    if (code >= 8 && code < 20) return "R5";
    return "R7";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] accPat [5];
    logic [15:0] held;
    logic e;
    int n = 0;
    accPat[0] = 16'h0000; accPat[1] = 16'h0001; accPat[2] = 16'h8000;
    accPat[3] = 16'h7FFF; accPat[4] = 16'hFFFF;

    pcIn = 16'h1234;
    #23;
    check("R1", pcOut, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", pcOut, 0);

    // exhaustive sweep of codes, flags and accumulator patterns
    for (int c = 0; c < 32; c++)
      for (int ai = 0; ai < 5; ai++)
        for (int l = 0; l < 2; l++)
          for (int ds = 0; ds < 2; ds++)
            for (int dr = 0; dr < 64; dr++) begin
              @(negedge clk);
              skipCode = 5'(c); acc = accPat[ai]; link = l[0];
              dispRunning = ds[0]; devReady = 6'(dr); execEn = 1'b1;
              n++;
              pcIn = (n % 7 == 0) ? 16'hFFFF : 16'(n * 37);
              e = expSkip(c, accPat[ai], l[0], 6'(dr), ds[0]);
              #1;
              check(reqOf(c), skipReq, e);
              @(posedge clk); #1;
              check("R8", pcOut, 16'(pcIn + 16'(e)));
            end

    // R9: disabled edges hold the counter even with a taken skip
    @(negedge clk);
    execEn = 1'b1; skipCode = 5'd1; acc = 16'd0; pcIn = 16'h0100;
    @(posedge clk); #1;
    check("R8", pcOut, 16'h0101);
    held = pcOut;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      execEn = 1'b0; pcIn = 16'(16'h4000 + k);
      @(posedge clk); #1;
      check("R9", pcOut, held);
    end
    // R8 wrap explicit
    @(negedge clk);
    execEn = 1'b1; skipCode = 5'd9; devReady = 6'd0; pcIn = 16'hFFFF;
    @(posedge clk); #1;
    check("R8", pcOut, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule